// File: doc/BRIEF.md
# Segmented Packet Frame Receiver

This block takes transaction-layer packets from a segmented valid/ready stream and rebuilds each one as a 128-bit header plus a dword payload. A beat carries several segments. Each segment has its own valid, start and end flags, a header slot, a group of data lanes and a set of sideband fields: region index, function number, virtual-function number with its own valid bit, an error field and a sequence tag. The receiver works out how many payload dwords each packet should carry from two header fields. It checks the start and end flags of every segment against that count and presents each good packet on a one-packet output handshake.

The descriptor (header, length, sideband) is shown on output registers. The payload sits in a lane-banked double buffer and is read back by dword index through a read port with a one-cycle delay. Framing faults are reported as a one-cycle pulse with a two-bit cause code. A packet that ends with the wrong length is dropped.

Top module: `tlp_seg_rx`

## Requirements
- R1: A beat is taken only on a clock edge where `in_valid` and `in_ready` are both high. `in_ready` is low in reset, while a taken beat is still being walked, and while `pkt_valid` is high.
- R2: If header bit 126 is 0, the packet carries no payload and `pkt_len` is 0. If it is 1, the dword count is header bits [105:96], and a value of 0 in that field means 1024.
- R3: Segments are handled in index order, starting with segment 0. A segment whose valid bit is clear is skipped. Packets that complete in one beat are presented in segment order.
- R4: Segment s lane k is `in_data[(s*LANES+k)*32 +: 32]`. A segment stores min(LANES, remaining) dwords. Lanes past the remaining count, and data segments that arrive after the count is used up, leave the payload and the packet unchanged.
- R5: `pkt_bar`, `pkt_func`, `pkt_vf_act`, `pkt_err` and `pkt_seq` come from the packet's start segment. `pkt_vf_num` is the start segment's value when that segment's `in_vf_act` bit is 1, and 0 when it is not.
- R6: A start flag in a valid segment while a packet is open gives cause code 1. The open packet is dropped and the new one begins.
- R7: A valid segment without a start flag while no packet is open gives cause code 2. That segment is otherwise ignored.
- R8: An end flag while the remaining count is not zero gives cause code 3, and the packet is dropped. This code wins over code 1 when both occur in one segment.
- R9: While `pkt_valid` is high and `pkt_ready` is low, the descriptor outputs hold steady. `pkt_rd_data` returns payload dword `pkt_rd_addr` of the presented packet one cycle after the address is applied.
- R10: `frame_err` is high for exactly one cycle for each faulty segment. `frame_err_code` holds a nonzero cause code during that cycle.
- R11: A packet can be assembled while the previous one is still presented. A segment that would end a packet waits until the presented packet has been accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Beat valid |
| in_ready | output | 1 | Beat ready |
| in_seg_valid | input | SEGS | Per-segment valid |
| in_sop | input | SEGS | Per-segment packet start |
| in_eop | input | SEGS | Per-segment packet end |
| in_hdr | input | SEGS*128 | Header slots |
| in_data | input | SEGS*LANES*32 | Data lanes |
| in_bar | input | SEGS*3 | Region index per segment |
| in_func | input | SEGS*8 | Function number per segment |
| in_vf_act | input | SEGS | Virtual-function number valid |
| in_vf_num | input | SEGS*11 | Virtual-function number |
| in_err | input | SEGS*4 | Error field |
| in_seq | input | SEGS*SEQ_W | Sequence tag |
| pkt_valid | output | 1 | Packet presented |
| pkt_ready | input | 1 | Packet accepted |
| pkt_hdr | output | 128 | Packet header |
| pkt_len | output | 11 | Payload length in dwords |
| pkt_bar | output | 3 | Region index |
| pkt_func | output | 8 | Function number |
| pkt_vf_act | output | 1 | Virtual-function valid |
| pkt_vf_num | output | 11 | Virtual-function number, 0 when not valid |
| pkt_err | output | 4 | Error field |
| pkt_seq | output | SEQ_W | Sequence tag |
| pkt_rd_addr | input | 10 | Payload dword index |
| pkt_rd_data | output | 32 | Payload dword, one cycle after address |
| frame_err | output | 1 | Framing fault pulse |
| frame_err_code | output | 2 | Fault cause: 1 start-in-packet, 2 orphan data, 3 length |

## Verification
A beat taken at edge E has segment i handled at edge E+1+i unless that segment is held by R11. The packet descriptor or fault pulse for that segment shows from that edge, and a payload read shows one edge after its address. The bench drives and samples only at falling edges. It waits for `pkt_valid` with bounded polling loops instead of fixed delays, so a stalled second packet is still caught in the right order. It reads payload one address per cycle and tallies fault pulses on falling edges, comparing the tally only after the segment concerned has been walked.

// File: rtl/tsr_pkg.sv
package tsr_pkg;
  localparam int HDR_W  = 128;
  localparam int DW_W   = 32;
  localparam int BAR_W  = 3;
  localparam int FN_W   = 8;
  localparam int VF_W   = 11;
  localparam int ERR_W  = 4;
  localparam int MAX_DW = 1024;
  localparam int LEN_W  = $clog2(MAX_DW) + 1;
  localparam int ADR_W  = $clog2(MAX_DW);
  localparam int HAS_DATA_BIT = 126;
  localparam int LEN_LSB      = 96;

  typedef enum logic [1:0] {
    FE_NONE     = 2'd0,
    FE_SOP_OPEN = 2'd1,
    FE_ORPHAN   = 2'd2,
    FE_LENGTH   = 2'd3
  } ferr_e;

  typedef struct packed {
    logic [BAR_W-1:0] bar;
    logic [FN_W-1:0]  fn;
    logic             vf_act;
    logic [VF_W-1:0]  vf;
    logic [ERR_W-1:0] err;
  } side_t;

  // payload dword count implied by a header
  function automatic logic [LEN_W-1:0] expect_dw(input logic [HDR_W-1:0] h);
    if (!h[HAS_DATA_BIT]) return '0;
    if (h[LEN_LSB +: 10] == 10'd0) return LEN_W'(MAX_DW);
    return {1'b0, h[LEN_LSB +: 10]};
  endfunction
endpackage

// File: rtl/tsr_lane_ram.sv
module tsr_lane_ram import tsr_pkg::*; #(
  parameter int LANES = 4,
  parameter int ROWS  = 512
) (
  input  logic                    clk,
  input  logic [LANES-1:0]        we,
  input  logic [$clog2(ROWS)-1:0] waddr,
  input  logic [LANES*DW_W-1:0]   wdata,
  input  logic [$clog2(ROWS)-1:0] raddr,
  input  logic [$clog2(LANES)-1:0] rlane,
  output logic [DW_W-1:0]         rdata
);
  localparam int RA_W = $clog2(ROWS);
  localparam int LN_W = $clog2(LANES);

  logic [DW_W-1:0] lane_q [LANES];
  logic [LN_W-1:0] rlane_q;

  // one simple dual-port memory per lane
  for (genvar l = 0; l < LANES; l++) begin : g_lane
    logic [DW_W-1:0] mem [ROWS];
    logic [DW_W-1:0] rq;
    always_ff @(posedge clk) begin
      if (we[l]) mem[waddr] <= wdata[l*DW_W +: DW_W];
      rq <= mem[raddr];
    end
    assign lane_q[l] = rq;
  end

  always_ff @(posedge clk) rlane_q <= rlane;
  assign rdata = lane_q[rlane_q];
endmodule

// File: rtl/tsr_framer.sv
module tsr_framer import tsr_pkg::*; #(
  parameter int LANES = 4,
  parameter int SEQ_W = 6
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  go,
  input  logic                  seg_valid,
  input  logic                  seg_sop,
  input  logic                  seg_eop,
  input  logic [HDR_W-1:0]      seg_hdr,
  input  logic [LANES*DW_W-1:0] seg_data,
  input  side_t                 seg_side,
  input  logic [SEQ_W-1:0]      seg_seq,
  output logic                  stall,
  output logic [LANES-1:0]      ram_we,
  output logic [$clog2(MAX_DW/LANES):0] ram_row,
  output logic [LANES*DW_W-1:0] ram_wdata,
  output logic                  pkt_valid,
  input  logic                  pkt_ready,
  output logic [HDR_W-1:0]      pkt_hdr,
  output logic [LEN_W-1:0]      pkt_len,
  output side_t                 pkt_side,
  output logic [SEQ_W-1:0]      pkt_seq,
  output logic                  pkt_bank,
  output logic                  ferr,
  output logic [1:0]            ferr_code
);
  localparam int ROW_W = $clog2(MAX_DW/LANES);

  logic             open_q, asm_bank_q;
  logic [LEN_W-1:0] rem_q, cur_len;
  logic [ROW_W-1:0] row_q;
  logic [HDR_W-1:0] cur_hdr;
  side_t            cur_side, side_m;
  logic [SEQ_W-1:0] cur_seq;

  logic             step, live;
  logic [LEN_W-1:0] base_rem, take, rem_after;
  logic [ROW_W-1:0] base_row;

  always_comb begin
    stall     = go && seg_valid && seg_eop && pkt_valid;
    step      = go && seg_valid && !stall;
    live      = seg_sop || open_q;
    base_rem  = seg_sop ? expect_dw(seg_hdr) : rem_q;
    base_row  = seg_sop ? '0 : row_q;
    take      = (base_rem >= LEN_W'(LANES)) ? LEN_W'(LANES) : base_rem;
    rem_after = base_rem - take;
    for (int l = 0; l < LANES; l++)
      ram_we[l] = step && live && (take > LEN_W'(l));
    ram_row   = {asm_bank_q, base_row};
    ram_wdata = seg_data;
    side_m    = seg_side;
    if (!seg_side.vf_act) side_m.vf = '0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      open_q     <= 1'b0;
      asm_bank_q <= 1'b0;
      rem_q      <= '0;
      row_q      <= '0;
      pkt_valid  <= 1'b0;
      pkt_bank   <= 1'b0;
      ferr       <= 1'b0;
      ferr_code  <= FE_NONE;
    end else begin
      ferr      <= 1'b0;
      ferr_code <= FE_NONE;
      if (pkt_valid && pkt_ready) pkt_valid <= 1'b0;
      if (step) begin
        if (!live) begin
          ferr      <= 1'b1;
          ferr_code <= FE_ORPHAN;
        end else begin
          if (seg_sop && open_q) begin
            ferr      <= 1'b1;
            ferr_code <= FE_SOP_OPEN;
          end
          if (seg_sop) begin
            cur_hdr  <= seg_hdr;
            cur_side <= side_m;
            cur_seq  <= seg_seq;
            cur_len  <= base_rem;
          end
          rem_q  <= rem_after;
          row_q  <= base_row + ROW_W'(take != '0);
          open_q <= !seg_eop;
          if (seg_eop) begin
            if (rem_after == '0) begin
              pkt_valid  <= 1'b1;
              pkt_hdr    <= seg_sop ? seg_hdr  : cur_hdr;
              pkt_len    <= seg_sop ? base_rem : cur_len;
              pkt_side   <= seg_sop ? side_m   : cur_side;
              pkt_seq    <= seg_sop ? seg_seq  : cur_seq;
              pkt_bank   <= asm_bank_q;
              asm_bank_q <= !asm_bank_q;
            end else begin
              ferr      <= 1'b1;
              ferr_code <= FE_LENGTH;
            end
          end
        end
      end
    end
  end

  // R9: presented packet is held until taken
  a_r9_hold_desc: assert property (@(posedge clk) disable iff (rst)
    pkt_valid && !pkt_ready |=> pkt_valid && $stable(pkt_hdr) && $stable(pkt_len) && $stable(pkt_seq));
  // R2: no payload without the has-data bit
  a_r2_nodata_len: assert property (@(posedge clk) disable iff (rst)
    pkt_valid && !pkt_hdr[HAS_DATA_BIT] |-> pkt_len == '0);
  // R2: payload length with data lies in 1..1024
  a_r2_len_bound: assert property (@(posedge clk) disable iff (rst)
    pkt_valid && pkt_hdr[HAS_DATA_BIT] |-> (pkt_len != '0) && (pkt_len <= LEN_W'(MAX_DW)));
  // R10: a fault pulse always carries a cause
  a_r10_code: assert property (@(posedge clk) disable iff (rst)
    ferr |-> ferr_code != FE_NONE);
  // R4: remaining count never exceeds the largest packet
  a_r4_rem_bound: assert property (@(posedge clk) disable iff (rst)
    rem_q <= LEN_W'(MAX_DW));
  // R11: a new packet is never presented over an untaken one
  a_r11_no_overwrite: assert property (@(posedge clk) disable iff (rst)
    pkt_valid && !pkt_ready |=> $stable(pkt_bank));
endmodule

// File: rtl/tlp_seg_rx.sv
module tlp_seg_rx import tsr_pkg::*; #(
  parameter int SEGS  = 2,
  parameter int LANES = 4,
  parameter int SEQ_W = 6
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      in_valid,
  output logic                      in_ready,
  input  logic [SEGS-1:0]           in_seg_valid,
  input  logic [SEGS-1:0]           in_sop,
  input  logic [SEGS-1:0]           in_eop,
  input  logic [SEGS*HDR_W-1:0]     in_hdr,
  input  logic [SEGS*LANES*DW_W-1:0] in_data,
  input  logic [SEGS*BAR_W-1:0]     in_bar,
  input  logic [SEGS*FN_W-1:0]      in_func,
  input  logic [SEGS-1:0]           in_vf_act,
  input  logic [SEGS*VF_W-1:0]      in_vf_num,
  input  logic [SEGS*ERR_W-1:0]     in_err,
  input  logic [SEGS*SEQ_W-1:0]     in_seq,
  output logic                      pkt_valid,
  input  logic                      pkt_ready,
  output logic [HDR_W-1:0]          pkt_hdr,
  output logic [LEN_W-1:0]          pkt_len,
  output logic [BAR_W-1:0]          pkt_bar,
  output logic [FN_W-1:0]           pkt_func,
  output logic                      pkt_vf_act,
  output logic [VF_W-1:0]           pkt_vf_num,
  output logic [ERR_W-1:0]          pkt_err,
  output logic [SEQ_W-1:0]          pkt_seq,
  input  logic [ADR_W-1:0]          pkt_rd_addr,
  output logic [DW_W-1:0]           pkt_rd_data,
  output logic                      frame_err,
  output logic [1:0]                frame_err_code
);
  localparam int IDX_W = (SEGS > 1) ? $clog2(SEGS) : 1;
  localparam int LN_W  = $clog2(LANES);
  localparam int ROWS  = 2 * MAX_DW / LANES;
  localparam int ROW_W = $clog2(MAX_DW/LANES);
  localparam int SD_W  = LANES * DW_W;

  // captured beat
  logic                 busy_q;
  logic [IDX_W-1:0]     idx_q;
  logic [SEGS-1:0]      b_sv, b_sop, b_eop, b_vfa;
  logic [SEGS*HDR_W-1:0] b_hdr;
  logic [SEGS*SD_W-1:0] b_data;
  logic [SEGS*BAR_W-1:0] b_bar;
  logic [SEGS*FN_W-1:0] b_fn;
  logic [SEGS*VF_W-1:0] b_vf;
  logic [SEGS*ERR_W-1:0] b_err;
  logic [SEGS*SEQ_W-1:0] b_seq;

  logic                 stall, pkt_bank;
  logic [LANES-1:0]     ram_we;
  logic [ROW_W:0]       ram_row;
  logic [SD_W-1:0]      ram_wdata;
  side_t                seg_side, pkt_side;

  assign in_ready = !rst && !busy_q && !pkt_valid;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q <= 1'b0;
      idx_q  <= '0;
    end else if (in_valid && in_ready) begin
      busy_q <= 1'b1;
      idx_q  <= '0;
      b_sv   <= in_seg_valid;
      b_sop  <= in_sop;
      b_eop  <= in_eop;
      b_hdr  <= in_hdr;
      b_data <= in_data;
      b_bar  <= in_bar;
      b_fn   <= in_func;
      b_vfa  <= in_vf_act;
      b_vf   <= in_vf_num;
      b_err  <= in_err;
      b_seq  <= in_seq;
    end else if (busy_q && !stall) begin
      if (idx_q == IDX_W'(SEGS-1)) busy_q <= 1'b0;
      else                         idx_q  <= idx_q + 1'b1;
    end
  end

  always_comb begin
    seg_side.bar    = b_bar[idx_q*BAR_W +: BAR_W];
    seg_side.fn     = b_fn[idx_q*FN_W +: FN_W];
    seg_side.vf_act = b_vfa[idx_q];
    seg_side.vf     = b_vf[idx_q*VF_W +: VF_W];
    seg_side.err    = b_err[idx_q*ERR_W +: ERR_W];
  end

  tsr_framer #(.LANES(LANES), .SEQ_W(SEQ_W)) i_framer (
    .clk       (clk),
    .rst       (rst),
    .go        (busy_q),
    .seg_valid (b_sv[idx_q]),
    .seg_sop   (b_sop[idx_q]),
    .seg_eop   (b_eop[idx_q]),
    .seg_hdr   (b_hdr[idx_q*HDR_W +: HDR_W]),
    .seg_data  (b_data[idx_q*SD_W +: SD_W]),
    .seg_side  (seg_side),
    .seg_seq   (b_seq[idx_q*SEQ_W +: SEQ_W]),
    .stall     (stall),
    .ram_we    (ram_we),
    .ram_row   (ram_row),
    .ram_wdata (ram_wdata),
    .pkt_valid (pkt_valid),
    .pkt_ready (pkt_ready),
    .pkt_hdr   (pkt_hdr),
    .pkt_len   (pkt_len),
    .pkt_side  (pkt_side),
    .pkt_seq   (pkt_seq),
    .pkt_bank  (pkt_bank),
    .ferr      (frame_err),
    .ferr_code (frame_err_code)
  );

  tsr_lane_ram #(.LANES(LANES), .ROWS(ROWS)) i_ram (
    .clk   (clk),
    .we    (ram_we),
    .waddr (ram_row),
    .wdata (ram_wdata),
    .raddr ({pkt_bank, pkt_rd_addr[ADR_W-1:LN_W]}),
    .rlane (pkt_rd_addr[LN_W-1:0]),
    .rdata (pkt_rd_data)
  );

  assign pkt_bar    = pkt_side.bar;
  assign pkt_func   = pkt_side.fn;
  assign pkt_vf_act = pkt_side.vf_act;
  assign pkt_vf_num = pkt_side.vf;
  assign pkt_err    = pkt_side.err;

  // R1: after a beat is taken, no further beat is taken on the next edge
  a_r1_one_beat: assert property (@(posedge clk) disable iff (rst)
    in_valid && in_ready |=> !in_ready);
  // R3: the segment walker stays inside the beat
  a_r3_idx_range: assert property (@(posedge clk) disable iff (rst)
    busy_q |-> idx_q <= IDX_W'(SEGS-1));
  // R5: a cleared virtual-function valid bit never shows a number
  a_r5_vf_zero: assert property (@(posedge clk) disable iff (rst)
    pkt_valid && !pkt_vf_act |-> pkt_vf_num == '0);
endmodule

// File: tb/test_tlp_seg_rx.sv
module test_tlp_seg_rx;
  localparam int CLK_PERIOD = 10;
  localparam int SEGS  = 2;
  localparam int LANES = 4;
  localparam int SEQ_W = 6;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_valid = 1'b0;
  logic in_ready;
  logic [SEGS-1:0] in_seg_valid, in_sop, in_eop, in_vf_act;
  logic [SEGS*128-1:0] in_hdr;
  logic [SEGS*LANES*32-1:0] in_data;
  logic [SEGS*3-1:0] in_bar;
  logic [SEGS*8-1:0] in_func;
  logic [SEGS*11-1:0] in_vf_num;
  logic [SEGS*4-1:0] in_err;
  logic [SEGS*SEQ_W-1:0] in_seq;
  logic pkt_valid;
  logic pkt_ready = 1'b0;
  logic [127:0] pkt_hdr;
  logic [10:0] pkt_len;
  logic [2:0] pkt_bar;
  logic [7:0] pkt_func;
  logic pkt_vf_act;
  logic [10:0] pkt_vf_num;
  logic [3:0] pkt_err;
  logic [SEQ_W-1:0] pkt_seq;
  logic [9:0] pkt_rd_addr = '0;
  logic [31:0] pkt_rd_data;
  logic frame_err;
  logic [1:0] frame_err_code;

  int checks = 0;
  int errors = 0;
  int ferr_cnt = 0;
  int ferr_last = 0;
  bit done = 1'b0;

  tlp_seg_rx #(.SEGS(SEGS), .LANES(LANES), .SEQ_W(SEQ_W)) i_tlp_seg_rx (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_seg_valid(in_seg_valid), .in_sop(in_sop), .in_eop(in_eop),
    .in_hdr(in_hdr), .in_data(in_data), .in_bar(in_bar), .in_func(in_func),
    .in_vf_act(in_vf_act), .in_vf_num(in_vf_num), .in_err(in_err), .in_seq(in_seq),
    .pkt_valid(pkt_valid), .pkt_ready(pkt_ready), .pkt_hdr(pkt_hdr), .pkt_len(pkt_len),
    .pkt_bar(pkt_bar), .pkt_func(pkt_func), .pkt_vf_act(pkt_vf_act),
    .pkt_vf_num(pkt_vf_num), .pkt_err(pkt_err), .pkt_seq(pkt_seq),
    .pkt_rd_addr(pkt_rd_addr), .pkt_rd_data(pkt_rd_data),
    .frame_err(frame_err), .frame_err_code(frame_err_code)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(negedge clk) begin
    if (!rst && frame_err) begin
      ferr_cnt  = ferr_cnt + 1;
      ferr_last = int'(frame_err_code);
    end
  end

  task automatic chk(input string req, input string what, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic logic [127:0] mk_hdr(input bit hd, input int len, input int tag);
    logic [127:0] h;
    h = '0;
    h[126] = hd;
    h[105:96] = len[9:0];
    h[7:0] = tag[7:0];
    return h;
  endfunction

  task automatic clr_beat();
    in_seg_valid = '0; in_sop = '0; in_eop = '0; in_vf_act = '0;
    in_hdr = '0; in_data = '0; in_bar = '0; in_func = '0;
    in_vf_num = '0; in_err = '0; in_seq = '0;
  endtask

  // sideband of a segment is derived from its tag
  task automatic set_seg(input int s, input bit sop, input bit eop, input logic [127:0] h,
                         input int dbase, input int ndw, input int tag);
    in_seg_valid[s] = 1'b1;
    in_sop[s] = sop;
    in_eop[s] = eop;
    in_hdr[s*128 +: 128] = h;
    for (int k = 0; k < LANES; k++)
      in_data[(s*LANES+k)*32 +: 32] = (k < ndw) ? 32'(dbase + k) : 32'hBAD0_0000 + 32'(k);
    in_bar[s*3 +: 3] = 3'(tag % 8);
    in_func[s*8 +: 8] = 8'(tag);
    in_vf_act[s] = (tag % 2) == 1;
    in_vf_num[s*11 +: 11] = 11'h400 | 11'(tag);
    in_err[s*4 +: 4] = 4'(tag % 16);
    in_seq[s*SEQ_W +: SEQ_W] = SEQ_W'(tag % 64);
  endtask

  task automatic send_beat();
    in_valid = 1'b1;
    while (!in_ready) @(negedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    clr_beat();
  endtask

  task automatic expect_pkt(input string req, input int tag, input int len, input int dbase);
    int wait_n = 0;
    int bad = 0;
    while (!pkt_valid && wait_n < 400) begin
      @(negedge clk);
      wait_n++;
    end
    chk(req, "pkt_valid", longint'(pkt_valid), 1);
    chk(req, "header tag", longint'(pkt_hdr[7:0]), longint'(tag));
    chk(req, "pkt_len", longint'(pkt_len), longint'(len));
    chk("R5", "pkt_bar", longint'(pkt_bar), longint'(tag % 8));
    chk("R5", "pkt_func", longint'(pkt_func), longint'(tag % 256));
    chk("R5", "pkt_vf_act", longint'(pkt_vf_act), longint'(tag % 2));
    chk("R5", "pkt_vf_num", longint'(pkt_vf_num), (tag % 2 == 1) ? longint'(11'h400 | 11'(tag)) : 0);
    chk("R5", "pkt_err", longint'(pkt_err), longint'(tag % 16));
    chk("R5", "pkt_seq", longint'(pkt_seq), longint'(tag % 64));
    for (int i = 0; i < len; i++) begin
      pkt_rd_addr = 10'(i);
      @(negedge clk);
      if (pkt_rd_data != 32'(dbase + i)) begin
        if (bad == 0) $display("payload dword %0d actual=%0d expected=%0d", i, pkt_rd_data, dbase + i);
        bad++;
      end
    end
    chk("R4", "payload mismatches", bad, 0);
    pkt_ready = 1'b1;
    @(negedge clk);
    pkt_ready = 1'b0;
  endtask

  task automatic expect_none(input string req, input int cyc);
    repeat (cyc) @(negedge clk);
    chk(req, "no packet presented", longint'(pkt_valid), 0);
  endtask

  task automatic t_reset();
    chk("R1", "in_ready in reset", longint'(in_ready), 0);
    chk("R1", "pkt_valid in reset", longint'(pkt_valid), 0);
    @(negedge clk); rst = 1'b0;
    @(negedge clk);
    chk("R1", "in_ready after reset", longint'(in_ready), 1);
    chk("R10", "frame_err after reset", longint'(frame_err), 0);
  endtask

  task automatic t_header_only();
    set_seg(0, 1, 1, mk_hdr(0, 5, 8'h06), 0, 0, 8'h06);
    send_beat();
    expect_pkt("R2", 8'h06, 0, 0);
    set_seg(1, 1, 1, mk_hdr(0, 9, 8'h07), 0, 0, 8'h07);
    send_beat();
    expect_pkt("R5", 8'h07, 0, 0);
  endtask

  task automatic t_two_in_beat();
    int e0 = ferr_cnt;
    set_seg(0, 1, 1, mk_hdr(1, 3, 8'h11), 100, 3, 8'h11);
    set_seg(1, 1, 1, mk_hdr(1, 4, 8'h12), 200, 4, 8'h12);
    send_beat();
    repeat (6) @(negedge clk);
    chk("R9", "held pkt_valid", longint'(pkt_valid), 1);
    chk("R9", "held header tag", longint'(pkt_hdr[7:0]), 8'h11);
    chk("R1", "in_ready while presented", longint'(in_ready), 0);
    expect_pkt("R3", 8'h11, 3, 100);
    expect_pkt("R11", 8'h12, 4, 200);
    chk("R10", "no fault pulses", ferr_cnt - e0, 0);
  endtask

  task automatic t_multi_beat();
    set_seg(0, 1, 0, mk_hdr(1, 10, 8'h21), 300, 4, 8'h21);
    set_seg(1, 0, 0, '0, 304, 4, 0);
    send_beat();
    set_seg(1, 0, 1, '0, 308, 2, 0);
    send_beat();
    expect_pkt("R3", 8'h21, 10, 300);
  endtask

  task automatic t_max_len();
    for (int b = 0; b < 128; b++) begin
      set_seg(0, b == 0, 0, (b == 0) ? mk_hdr(1, 0, 8'h2B) : '0, 5000 + 8*b, 4, 8'h2B);
      set_seg(1, 0, b == 127, '0, 5004 + 8*b, 4, 0);
      send_beat();
    end
    expect_pkt("R2", 8'h2B, 1024, 5000);
  endtask

  task automatic t_sop_open();
    int e0 = ferr_cnt;
    set_seg(0, 1, 0, mk_hdr(1, 8, 8'h31), 600, 4, 8'h31);
    set_seg(1, 1, 1, mk_hdr(0, 7, 8'h32), 0, 0, 8'h32);
    send_beat();
    expect_pkt("R6", 8'h32, 0, 0);
    chk("R6", "fault count", ferr_cnt - e0, 1);
    chk("R6", "fault code", ferr_last, 1);
  endtask

  task automatic t_orphan();
    int e0 = ferr_cnt;
    set_seg(0, 0, 0, '0, 700, 4, 0);
    send_beat();
    expect_none("R7", 6);
    chk("R7", "fault code", ferr_last, 2);
    chk("R10", "one pulse per faulty segment", ferr_cnt - e0, 1);
  endtask

  task automatic t_early_end();
    int e0 = ferr_cnt;
    set_seg(0, 1, 1, mk_hdr(1, 8, 8'h35), 800, 4, 8'h35);
    send_beat();
    expect_none("R8", 6);
    chk("R8", "fault code", ferr_last, 3);
    chk("R8", "fault count", ferr_cnt - e0, 1);
    set_seg(0, 1, 1, mk_hdr(1, 2, 8'h36), 900, 2, 8'h36);
    send_beat();
    expect_pkt("R8", 8'h36, 2, 900);
  endtask

  task automatic t_extra_data();
    int e0 = ferr_cnt;
    set_seg(0, 1, 0, mk_hdr(1, 2, 8'h41), 400, 2, 8'h41);
    set_seg(1, 0, 0, '0, 32'h0BAD_0000, 0, 0);
    send_beat();
    set_seg(0, 0, 1, '0, 32'h0BAD_1000, 0, 0);
    send_beat();
    expect_pkt("R4", 8'h41, 2, 400);
    chk("R4", "no fault for surplus data", ferr_cnt - e0, 0);
  endtask

  initial begin
    clr_beat();
    repeat (3) @(negedge clk);
    t_reset();
    t_header_only();
    t_two_in_beat();
    t_multi_beat();
    t_max_len();
    t_sop_open();
    t_orphan();
    t_early_end();
    t_extra_data();
    if (!done) begin
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL R1 watchdog actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule